// File: doc/BRIEF.md
# Reset Qualification and Boot Mode Selector

This block sits behind the reset pad and the program-strobe pad of a small controller and runs on the oscillator clock. It decides when the core is held in reset and, when that reset ends, which of two start-up modes follows: ordinary execution, or a programming mode driven by an external host. Both pads are brought into the clock domain through two-flop synchronizers before any counting or edge detection.

While the synchronized reset pad is high, the block counts machine-cycle ticks in a saturating counter. The counter clears whenever the pad is low. The internal reset is asserted only once two ticks have been counted, so shorter pulses on the pad are filtered out. A falling edge on the program-strobe pad is remembered as a host request, but only if the reset pad has been high for more than ten ticks when that edge arrives. The request is dropped once the reset pad goes low. When the internal reset ends, the request selects host mode and its absence selects normal mode. The chosen flag then holds until the next qualified reset.

All pins are plain level signals. There is no data stream, so no valid/ready handshake applies.

Top module: `boot_mode_detect`

## Requirements
- R1: A change on `reset_pad_i` reaches the internal logic through two clock edges. After the pad falls, `sys_rst_o` is still high after the first edge and low after the second.
- R2: `sys_rst_o` rises in the same clock edge that registers the second `mc_tick_i` pulse seen while the synchronized reset pad is high. It stays high until the synchronized pad is low.
- R3: A reset-pad pulse during which fewer than two ticks are counted leaves `sys_rst_o` low and both mode flags unchanged.
- R4: Ticks are counted only while the synchronized reset pad is high. The count saturates, so any hold length beyond the host threshold still qualifies. The count restarts from zero at every new reset.
- R5: A high-to-low transition on `prog_strobe_i` after more than ten ticks of the current reset hold selects host mode when the reset ends: `host_mode_o`=1, `run_mode_o`=0.
- R6: A high-to-low transition on `prog_strobe_i` after ten or fewer ticks of the current hold is ignored, and normal mode follows: `run_mode_o`=1, `host_mode_o`=0.
- R7: A qualified reset with no strobe falling edge ends in normal mode.
- R8: Strobe transitions while the reset pad is low have no effect on the mode chosen at the next release.
- R9: `host_mode_o` and `run_mode_o` are never both high. Both are low after `por_ni` and during the internal reset. The chosen flag is set one clock after `sys_rst_o` falls and holds until the next internal reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| por_ni | input | 1 | Asynchronous power-on clear, active low |
| mc_tick_i | input | 1 | One-clock pulse per machine cycle |
| reset_pad_i | input | 1 | Raw reset pad level, active high |
| prog_strobe_i | input | 1 | Raw program-strobe pad level |
| sys_rst_o | output | 1 | Qualified internal reset |
| host_mode_o | output | 1 | External programming-host mode selected |
| run_mode_o | output | 1 | Normal operation selected |

## Verification
A pad change reaches the internal logic two edges after it is driven. `sys_rst_o` follows on that second edge, or on the edge of the second counted tick, and the mode flags follow one edge after `sys_rst_o` falls. The bench drives every input on the falling clock edge and samples on a falling edge. The exact-latency checks sample at the edges listed above, while the table walk waits three clocks after each release before reading the flags. Each strobe edge is given four idle clocks before the next tick, so that the request is judged against the intended tick count.

// File: rtl/boot_mode_pkg.sv
package boot_mode_pkg;
  typedef enum logic [1:0] {
    BOOT_NONE = 2'd0,
    BOOT_RUN  = 2'd1,
    BOOT_HOST = 2'd2
  } boot_mode_t;
endpackage

// File: rtl/bmd_sync.sv
module bmd_sync #(
  parameter int          W    = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk_i,
  input  logic         por_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      stage1 <= INIT;
      q_o    <= INIT;
    end else begin
      stage1 <= d_i;
      q_o    <= stage1;
    end
  end
endmodule

// File: rtl/bmd_tick_count.sv
module bmd_tick_count #(
  parameter int SAT   = 11,
  parameter int CNT_W = $clog2(SAT + 1)
) (
  input  logic             clk_i,
  input  logic             por_ni,
  input  logic             hold_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] SAT_V = CNT_W'(SAT);

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)                       cnt_o <= '0;
    else if (!hold_i)                  cnt_o <= '0;
    else if (tick_i && cnt_o != SAT_V) cnt_o <= cnt_o + 1'b1;
  end

  // R4: never beyond saturation, stays saturated
  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!por_ni)
    cnt_o <= SAT_V);
  a_r4_sat_holds: assert property (@(posedge clk_i) disable iff (!por_ni)
    (hold_i && cnt_o == SAT_V) |=> cnt_o == SAT_V);
  a_r4_clear_low: assert property (@(posedge clk_i) disable iff (!por_ni)
    !hold_i |=> cnt_o == '0);
endmodule

// File: rtl/bmd_mode_ctrl.sv
module bmd_mode_ctrl
  import boot_mode_pkg::*;
#(
  parameter int RESET_CYC    = 2,
  parameter int HOST_MIN_CYC = 10,
  parameter int CNT_W        = 4
) (
  input  logic             clk_i,
  input  logic             por_ni,
  input  logic             hold_i,
  input  logic             strobe_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             sys_rst_o,
  output logic             host_o,
  output logic             run_o
);
  localparam logic [CNT_W-1:0] RST_V  = CNT_W'(RESET_CYC);
  localparam logic [CNT_W-1:0] HOST_V = CNT_W'(HOST_MIN_CYC);

  logic       strobe_q;
  logic       strobe_fall;
  logic       host_req;
  logic       in_rst_q;
  boot_mode_t mode_q;

  assign strobe_fall = strobe_q & ~strobe_i;
  assign sys_rst_o   = hold_i && (cnt_i >= RST_V);

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      strobe_q <= 1'b1;
      host_req <= 1'b0;
      in_rst_q <= 1'b0;
      mode_q   <= BOOT_NONE;
    end else begin
      strobe_q <= strobe_i;
      in_rst_q <= sys_rst_o;
      if (!hold_i)                             host_req <= 1'b0;
      else if (strobe_fall && cnt_i > HOST_V)  host_req <= 1'b1;
      if (sys_rst_o)     mode_q <= BOOT_NONE;
      else if (in_rst_q) mode_q <= host_req ? BOOT_HOST : BOOT_RUN;
    end
  end

  assign host_o = (mode_q == BOOT_HOST);
  assign run_o  = (mode_q == BOOT_RUN);

  // R9: flags exclusive, cleared in reset, held outside release
  a_r9_exclusive: assert property (@(posedge clk_i) disable iff (!por_ni)
    !(host_o && run_o));
  a_r9_clear_in_reset: assert property (@(posedge clk_i) disable iff (!por_ni)
    sys_rst_o |=> !host_o && !run_o);
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!por_ni)
    (!sys_rst_o && !in_rst_q) |=> $stable({host_o, run_o}));
  // R5/R6: a request only arises past the host threshold
  a_r5_req_threshold: assert property (@(posedge clk_i) disable iff (!por_ni)
    $rose(host_req) |-> $past(cnt_i) > HOST_V);
  // R2: internal reset needs the reset level
  a_r2_needs_hold: assert property (@(posedge clk_i) disable iff (!por_ni)
    !hold_i |-> !sys_rst_o);
endmodule

// File: rtl/boot_mode_detect.sv
module boot_mode_detect #(
  parameter int RESET_CYC    = 2,
  parameter int HOST_MIN_CYC = 10
) (
  input  logic clk_i,
  input  logic por_ni,
  input  logic mc_tick_i,
  input  logic reset_pad_i,
  input  logic prog_strobe_i,
  output logic sys_rst_o,
  output logic host_mode_o,
  output logic run_mode_o
);
  localparam int SAT   = (HOST_MIN_CYC + 1 > RESET_CYC) ? HOST_MIN_CYC + 1 : RESET_CYC;
  localparam int CNT_W = $clog2(SAT + 1);

  logic [1:0]       pad_s;
  logic [CNT_W-1:0] cnt;

  bmd_sync #(.W(2), .INIT(2'b10)) u_sync (
    .clk_i (clk_i),
    .por_ni(por_ni),
    .d_i   ({prog_strobe_i, reset_pad_i}),
    .q_o   (pad_s)
  );

  bmd_tick_count #(.SAT(SAT), .CNT_W(CNT_W)) u_count (
    .clk_i (clk_i),
    .por_ni(por_ni),
    .hold_i(pad_s[0]),
    .tick_i(mc_tick_i),
    .cnt_o (cnt)
  );

  bmd_mode_ctrl #(
    .RESET_CYC   (RESET_CYC),
    .HOST_MIN_CYC(HOST_MIN_CYC),
    .CNT_W       (CNT_W)
  ) u_ctrl (
    .clk_i    (clk_i),
    .por_ni   (por_ni),
    .hold_i   (pad_s[0]),
    .strobe_i (pad_s[1]),
    .cnt_i    (cnt),
    .sys_rst_o(sys_rst_o),
    .host_o   (host_mode_o),
    .run_o    (run_mode_o)
  );

  // R1: the internal reset falls no sooner than two edges after the pad
  a_r1_sync_delay: assert property (@(posedge clk_i) disable iff (!por_ni)
    $fell(sys_rst_o) |-> !$past(reset_pad_i, 2));
endmodule

// File: tb/tb_boot_mode_detect.sv
module tb_boot_mode_detect;
  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic tick = 1'b0;
  logic pad = 1'b0;
  logic strobe = 1'b1;
  logic sys_rst, host, run;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  boot_mode_detect dut (
    .clk_i(clk), .por_ni(por_n), .mc_tick_i(tick), .reset_pad_i(pad),
    .prog_strobe_i(strobe), .sys_rst_o(sys_rst), .host_mode_o(host),
    .run_mode_o(run)
  );

  // columns: ticks held, strobe fall after tick (0 = none), exp reset, exp host, exp run
  localparam int NV = 7;
  localparam int VEC [NV][5] = '{
    '{15, 11, 1, 1, 0},
    '{ 1,  0, 0, 1, 0},
    '{ 2,  0, 1, 0, 1},
    '{20, 20, 1, 1, 0},
    '{15, 10, 1, 0, 1},
    '{11, 11, 1, 1, 0},
    '{12,  0, 1, 0, 1}
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    clocks(2);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    clocks(3);
    // R9: power-on state
    check("R9 por sys_rst", sys_rst, 1'b0);
    check("R9 por host", host, 1'b0);
    check("R9 por run", run, 1'b0);
    por_n = 1'b1;
    clocks(3);

    for (int v = 0; v < NV; v++) begin
      pad = 1'b1;
      clocks(3);
      for (int t = 1; t <= VEC[v][0]; t++) begin
        do_tick();
        if (t == VEC[v][1]) begin
          strobe = 1'b0;
          clocks(4);
        end
      end
      check($sformatf("R2/R3 vec%0d sys_rst", v), sys_rst, VEC[v][2] != 0);
      if (VEC[v][2] != 0) begin
        check($sformatf("R9 vec%0d host in reset", v), host, 1'b0);
        check($sformatf("R9 vec%0d run in reset", v), run, 1'b0);
      end
      pad = 1'b0;
      clocks(3);
      check($sformatf("R5/R6/R7 vec%0d host", v), host, VEC[v][3] != 0);
      check($sformatf("R5/R6/R7 vec%0d run", v), run, VEC[v][4] != 0);
      strobe = 1'b1;
      clocks(3);
    end

    // R2: exact assertion edge, and R1: exact release latency
    pad = 1'b1;
    clocks(3);
    do_tick();
    check("R2 one tick no reset", sys_rst, 1'b0);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    check("R2 reset on second tick", sys_rst, 1'b1);
    clocks(2);
    pad = 1'b0;
    @(negedge clk);
    check("R1 still in reset after one edge", sys_rst, 1'b1);
    @(negedge clk);
    check("R1 reset off after two edges", sys_rst, 1'b0);
    check("R9 flag not yet set", run, 1'b0);
    @(negedge clk);
    check("R9 run one clock after release", run, 1'b1);
    clocks(5);
    check("R9 run held", run, 1'b1);

    // R8: strobe activity with reset pad low, then a plain reset
    strobe = 1'b0;
    clocks(4);
    strobe = 1'b1;
    clocks(4);
    strobe = 1'b0;
    clocks(4);
    check("R8 no effect while pad low", run, 1'b1);
    pad = 1'b1;
    clocks(3);
    for (int t = 0; t < 14; t++) do_tick();
    strobe = 1'b1;
    clocks(4);
    pad = 1'b0;
    clocks(3);
    check("R8 host stays low", host, 1'b0);
    check("R8 run after reset", run, 1'b1);

    // R4: counter restarts, a 3-tick hold after a long one gives no host request
    pad = 1'b1;
    clocks(3);
    for (int t = 0; t < 3; t++) do_tick();
    strobe = 1'b0;
    clocks(4);
    pad = 1'b0;
    clocks(3);
    check("R4 count restarted host", host, 1'b0);
    check("R4 count restarted run", run, 1'b1);
    strobe = 1'b1;
    clocks(3);

    done = 1'b1;
    summary();
  end
endmodule